// File: doc/BRIEF.md
# Bit-Addressable Special Register File

This block holds the special-purpose registers of a small 8-bit microcontroller core: the accumulator, a second operand register, the status word, the stack pointer, both halves of the data pointer, four I/O port latches, and the timer, serial, interrupt and power control registers. These registers live in the upper half (80h-FFh) of an 8-bit direct address space. The core reaches them through two independent ports. One is a byte port for whole-register reads and writes. The other is a single-bit port that reads, sets or clears one bit of a register whose byte address is a multiple of eight.

The file keeps the parity flag of the status word up to date in hardware, so that it always follows the accumulator. It also turns the two bank-select bits into the base address of the active working-register bank in lower RAM. The core's flag updates (carry, auxiliary carry, overflow) enter through a dedicated strobe. Any access to an undefined address in the upper half raises a one-cycle illegal-access pulse.

Top module: `sreg_file`

## Requirements
- R1: After reset the stack pointer reads 07h, the four port latches (80h, 90h, A0h, B0h) read FFh, every other defined register reads 00h, bank_base is 00h and illegal_pulse is low.
- R2: A byte write to a defined register address stores the data at the clock edge, and a byte read of that address then returns it without disturbing neighbouring addresses. The defined addresses are 80h-83h, 87h-8Dh, 90h, 98h, 99h, A0h, A8h, B0h, B8h, D0h (status), E0h (accumulator) and F0h.
- R3: Addresses 00h-7Fh are not decoded on either port: byte and bit reads there return 0, writes change nothing, and no illegal pulse follows.
- R4: A byte write to an undefined address in 80h-FFh is ignored and a byte read returns 00h. Every cycle with a byte or bit access to such an address makes illegal_pulse high for exactly the following cycle.
- R5: Bit address b (80h-FFh) selects bit b[2:0] of the register at byte address {b[7:3],000}. For example, bit address 8Ah is bit 2 of register 88h, not part of register 8Ah.
- R6: A bit write changes only the addressed bit of the target register, within one clock. The other seven bits keep their values.
- R7: Bit addresses whose 8-byte group holds no bit-addressable register (for example C0h-C7h, F8h-FFh) read 0 and ignore writes. Byte-only registers can never be reached through the bit port.
- R8: The status word (D0h) holds, from bit 7 down to bit 0: carry, auxiliary carry, user flag, bank select 1, bank select 0, overflow, user bit, parity.
- R9: Status bit 0 always equals the XOR of the accumulator bits, from the cycle after the accumulator changes. Writes to that bit, by byte or by bit, have no effect.
- R10: bank_base equals eight times the bank-select value in status bits 4:3, giving 00h, 08h, 10h or 18h.
- R11: With flag_we high, the status carry, auxiliary carry and overflow bits load flag_cy, flag_ac and flag_ov at the edge and the other bits hold. If a byte or bit write targets the status word in that same cycle, the software write is applied and the flag update is discarded.
- R12: If a byte write and a bit write target the same register in one cycle, the byte write wins. If they target different registers, both take effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| byte_addr | input | 8 | Byte port direct address |
| byte_rd | input | 1 | Byte read strobe (flags reserved accesses) |
| byte_wr | input | 1 | Byte write strobe |
| byte_wdata | input | 8 | Byte write data |
| byte_rdata | output | 8 | Byte read data for byte_addr (combinational) |
| bit_addr | input | 8 | Bit port address |
| bit_rd | input | 1 | Bit read strobe (flags reserved accesses) |
| bit_wr | input | 1 | Bit write strobe |
| bit_wval | input | 1 | Value written to the addressed bit |
| bit_rdata | output | 1 | Value of the addressed bit (combinational) |
| flag_we | input | 1 | Core strobe to load the arithmetic flags |
| flag_cy | input | 1 | Carry from the core |
| flag_ac | input | 1 | Auxiliary carry from the core |
| flag_ov | input | 1 | Overflow from the core |
| acc_value | output | 8 | Current accumulator |
| status_value | output | 8 | Current status word including parity |
| bank_base | output | 8 | Base address of the active register bank |
| illegal_pulse | output | 1 | One-cycle pulse after a reserved-address access |

## Verification
Two kinds of writer can land in the same cycle. The core's flag strobe can meet a software byte or bit write to the status word, and a byte write can meet a bit write on the same or a different register. The bench drives flag_we together with a byte write and, separately, together with a bit write to D0h. It judges the outcome from status_value, which must show the software value with the flags discarded. It also pairs byte and bit writes on one register and on two registers, then reads both back through the byte port.

// File: rtl/sreg_pkg.sv
package sreg_pkg;

  localparam int DW   = 8;
  localparam int AW   = 8;
  localparam int NREG = 21;
  localparam int IW   = $clog2(NREG);

  // register slots
  localparam int I_IO0   = 0;
  localparam int I_SP    = 1;
  localparam int I_DPL   = 2;
  localparam int I_DPH   = 3;
  localparam int I_PWR   = 4;
  localparam int I_TCTL  = 5;
  localparam int I_TMODE = 6;
  localparam int I_T0L   = 7;
  localparam int I_T1L   = 8;
  localparam int I_T0H   = 9;
  localparam int I_T1H   = 10;
  localparam int I_IO1   = 11;
  localparam int I_SCTL  = 12;
  localparam int I_SDAT  = 13;
  localparam int I_IO2   = 14;
  localparam int I_IEN   = 15;
  localparam int I_IO3   = 16;
  localparam int I_IPRI  = 17;
  localparam int I_STAT  = 18;
  localparam int I_ACC   = 19;
  localparam int I_BREG  = 20;

  // direct address of each slot, indexed by slot number
  localparam logic [AW-1:0] REG_ADDR [NREG] = '{
    8'h80, 8'h81, 8'h82, 8'h83, 8'h87, 8'h88, 8'h89, 8'h8A, 8'h8B, 8'h8C,
    8'h8D, 8'h90, 8'h98, 8'h99, 8'hA0, 8'hA8, 8'hB0, 8'hB8, 8'hD0, 8'hE0,
    8'hF0
  };

  // status word bit positions
  localparam int ST_CY  = 7;
  localparam int ST_AC  = 6;
  localparam int ST_UF  = 5;
  localparam int ST_BK1 = 4;
  localparam int ST_BK0 = 3;
  localparam int ST_OV  = 2;
  localparam int ST_UB  = 1;
  localparam int ST_PAR = 0;

  function automatic bit is_port_slot(input int i);
    return (i == I_IO0) || (i == I_IO1) || (i == I_IO2) || (i == I_IO3);
  endfunction

endpackage

// File: rtl/sreg_decode.sv
module sreg_decode
  import sreg_pkg::*;
#(
  parameter bit BIT_MODE = 1'b0
) (
  input  logic [AW-1:0] addr,
  output logic          hit,
  output logic [IW-1:0] idx,
  output logic          reserved
);

  localparam logic [AW-1:0] ADDR_MASK = BIT_MODE ? 8'hF8 : 8'hFF;

  logic [AW-1:0]   target;
  logic [NREG-1:0] match;

  assign target = addr & ADDR_MASK;

  for (genvar i = 0; i < NREG; i++) begin : g_match
    if (BIT_MODE) begin : g_bit
      // only slots on an 8-byte boundary answer the bit port
      assign match[i] = (REG_ADDR[i][2:0] == 3'b000) && (target == REG_ADDR[i]);
    end else begin : g_byte
      assign match[i] = (target == REG_ADDR[i]);
    end
  end

  always_comb begin
    idx = '0;
    for (int i = 0; i < NREG; i++) begin
      if (match[i]) idx = IW'(i);
    end
  end

  assign hit      = |match;
  assign reserved = addr[AW-1] & ~hit;

endmodule

// File: rtl/sreg_cell.sv
module sreg_cell
  import sreg_pkg::*;
#(
  parameter logic [DW-1:0] RST_VAL = '0,
  parameter logic [DW-1:0] KEEP    = '1
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   byte_we,
  input  logic [DW-1:0]          wdata,
  input  logic                   bit_we,
  input  logic [$clog2(DW)-1:0]  bit_sel,
  input  logic                   bit_val,
  input  logic                   hw_we,
  input  logic [DW-1:0]          hw_mask,
  input  logic [DW-1:0]          hw_val,
  output logic [DW-1:0]          q
);

  logic [DW-1:0] d;
  logic          en;

  // software byte > software bit > hardware flags
  always_comb begin
    d  = q;
    en = byte_we | bit_we | hw_we;
    if (byte_we) begin
      d = wdata;
    end else if (bit_we) begin
      d          = q;
      d[bit_sel] = bit_val;
    end else if (hw_we) begin
      d = (q & ~hw_mask) | (hw_val & hw_mask);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q <= RST_VAL & KEEP;
    end else if (en) begin
      q <= d & KEEP;
    end
  end

  a_r2_byte_load: assert property (@(posedge clk) disable iff (!rst_n)
    byte_we |=> q == ($past(wdata) & KEEP));

  a_r12_byte_beats_bit: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_we && bit_we) |=> q == ($past(wdata) & KEEP));

  a_r6_single_bit: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_we && !byte_we) |=> $countones(q ^ $past(q)) <= 1);

  a_r11_flags_only: assert property (@(posedge clk) disable iff (!rst_n)
    (hw_we && !byte_we && !bit_we) |=> ((q ^ $past(q)) & ~$past(hw_mask)) == '0);

endmodule

// File: rtl/sreg_status.sv
module sreg_status
  import sreg_pkg::*;
#(
  parameter int BANK_BYTES = 8
) (
  input  logic [DW-1:0] acc,
  input  logic [DW-1:0] stat_q,
  input  logic          flag_cy,
  input  logic          flag_ac,
  input  logic          flag_ov,
  output logic [DW-1:0] stat_view,
  output logic [DW-1:0] bank_base,
  output logic [DW-1:0] hw_mask,
  output logic [DW-1:0] hw_val
);

  localparam int BANK_SHIFT = $clog2(BANK_BYTES);

  logic parity;
  logic [1:0] bank_sel;

  assign parity   = ^acc;
  assign bank_sel = {stat_q[ST_BK1], stat_q[ST_BK0]};

  always_comb begin
    stat_view         = stat_q;
    stat_view[ST_PAR] = parity;
  end

  assign bank_base = DW'(bank_sel) << BANK_SHIFT;

  always_comb begin
    hw_mask        = '0;
    hw_mask[ST_CY] = 1'b1;
    hw_mask[ST_AC] = 1'b1;
    hw_mask[ST_OV] = 1'b1;
    hw_val         = '0;
    hw_val[ST_CY]  = flag_cy;
    hw_val[ST_AC]  = flag_ac;
    hw_val[ST_OV]  = flag_ov;
  end

endmodule

// File: rtl/sreg_file.sv
module sreg_file
  import sreg_pkg::*;
#(
  parameter logic [7:0] SP_INIT    = 8'h07,
  parameter logic [7:0] PORT_INIT  = 8'hFF,
  parameter int         BANK_BYTES = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [7:0] byte_addr,
  input  logic       byte_rd,
  input  logic       byte_wr,
  input  logic [7:0] byte_wdata,
  output logic [7:0] byte_rdata,
  input  logic [7:0] bit_addr,
  input  logic       bit_rd,
  input  logic       bit_wr,
  input  logic       bit_wval,
  output logic       bit_rdata,
  input  logic       flag_we,
  input  logic       flag_cy,
  input  logic       flag_ac,
  input  logic       flag_ov,
  output logic [7:0] acc_value,
  output logic [7:0] status_value,
  output logic [7:0] bank_base,
  output logic       illegal_pulse
);

  localparam int SEL_W = $clog2(DW);

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_sync;
  logic       rst_i_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_i_n = rst_sync[1];

  // address decode for both ports
  logic          bd_hit, bd_res, td_hit, td_res;
  logic [IW-1:0] bd_idx, td_idx;

  sreg_decode #(.BIT_MODE(1'b0)) u_byte_dec (
    .addr(byte_addr), .hit(bd_hit), .idx(bd_idx), .reserved(bd_res)
  );

  sreg_decode #(.BIT_MODE(1'b1)) u_bit_dec (
    .addr(bit_addr), .hit(td_hit), .idx(td_idx), .reserved(td_res)
  );

  // register storage
  logic [DW-1:0] regs_q [NREG];
  logic [DW-1:0] view   [NREG];
  logic [DW-1:0] stat_view, hw_mask, hw_val;

  sreg_status #(.BANK_BYTES(BANK_BYTES)) u_status (
    .acc      (regs_q[I_ACC]),
    .stat_q   (regs_q[I_STAT]),
    .flag_cy  (flag_cy),
    .flag_ac  (flag_ac),
    .flag_ov  (flag_ov),
    .stat_view(stat_view),
    .bank_base(bank_base),
    .hw_mask  (hw_mask),
    .hw_val   (hw_val)
  );

  for (genvar i = 0; i < NREG; i++) begin : g_reg
    localparam logic [DW-1:0] RV =
      (i == I_SP)       ? SP_INIT   :
      is_port_slot(i)   ? PORT_INIT : '0;
    localparam logic [DW-1:0] KP = (i == I_STAT) ? ~(DW'(1) << ST_PAR) : '1;

    logic byte_we_i, bit_we_i;
    assign byte_we_i = byte_wr & bd_hit & (bd_idx == IW'(i));
    assign bit_we_i  = bit_wr  & td_hit & (td_idx == IW'(i));

    if (i == I_STAT) begin : g_stat
      sreg_cell #(.RST_VAL(RV), .KEEP(KP)) u_cell (
        .clk(clk), .rst_n(rst_i_n),
        .byte_we(byte_we_i), .wdata(byte_wdata),
        .bit_we(bit_we_i), .bit_sel(bit_addr[SEL_W-1:0]), .bit_val(bit_wval),
        .hw_we(flag_we), .hw_mask(hw_mask), .hw_val(hw_val),
        .q(regs_q[i])
      );
    end else begin : g_plain
      sreg_cell #(.RST_VAL(RV), .KEEP(KP)) u_cell (
        .clk(clk), .rst_n(rst_i_n),
        .byte_we(byte_we_i), .wdata(byte_wdata),
        .bit_we(bit_we_i), .bit_sel(bit_addr[SEL_W-1:0]), .bit_val(bit_wval),
        .hw_we(1'b0), .hw_mask('0), .hw_val('0),
        .q(regs_q[i])
      );
    end
  end

  // read view with hardware parity overlaid
  always_comb begin
    for (int i = 0; i < NREG; i++) view[i] = regs_q[i];
    view[I_STAT] = stat_view;
  end

  assign byte_rdata   = bd_hit ? view[bd_idx] : '0;
  assign bit_rdata    = td_hit ? view[td_idx][bit_addr[SEL_W-1:0]] : 1'b0;
  assign acc_value    = regs_q[I_ACC];
  assign status_value = stat_view;

  // illegal-access pulse: next state and register
  logic illegal_d, illegal_q;

  assign illegal_d = ((byte_rd | byte_wr) & bd_res) | ((bit_rd | bit_wr) & td_res);

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) illegal_q <= 1'b0;
    else          illegal_q <= illegal_d;
  end
  assign illegal_pulse = illegal_q;

  a_r4_pulse_has_cause: assert property (@(posedge clk) disable iff (!rst_i_n)
    illegal_pulse |-> $past(byte_rd | byte_wr | bit_rd | bit_wr));

  a_r3_low_half_quiet: assert property (@(posedge clk) disable iff (!rst_i_n)
    ((byte_rd || byte_wr) && !byte_addr[7] && !bit_rd && !bit_wr) |=> !illegal_pulse);

  a_r3_low_bits_quiet: assert property (@(posedge clk) disable iff (!rst_i_n)
    ((bit_rd || bit_wr) && !bit_addr[7] && !byte_rd && !byte_wr) |=> !illegal_pulse);

  a_r9_parity_tracks_acc: assert property (@(posedge clk) disable iff (!rst_i_n)
    !$stable(acc_value) |-> (status_value[0] == ^acc_value));

endmodule

// File: tb/sreg_file_test.sv
`timescale 1ns/1ps
module sreg_file_test;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [7:0] byte_addr, byte_wdata, byte_rdata;
  logic       byte_rd, byte_wr;
  logic [7:0] bit_addr;
  logic       bit_rd, bit_wr, bit_wval, bit_rdata;
  logic       flag_we, flag_cy, flag_ac, flag_ov;
  logic [7:0] acc_value, status_value, bank_base;
  logic       illegal_pulse;

  always #2.5 clk = ~clk;

  sreg_file uut (
    .clk(clk), .rst_n(rst_n),
    .byte_addr(byte_addr), .byte_rd(byte_rd), .byte_wr(byte_wr),
    .byte_wdata(byte_wdata), .byte_rdata(byte_rdata),
    .bit_addr(bit_addr), .bit_rd(bit_rd), .bit_wr(bit_wr),
    .bit_wval(bit_wval), .bit_rdata(bit_rdata),
    .flag_we(flag_we), .flag_cy(flag_cy), .flag_ac(flag_ac), .flag_ov(flag_ov),
    .acc_value(acc_value), .status_value(status_value),
    .bank_base(bank_base), .illegal_pulse(illegal_pulse)
  );

  int total = 0;
  int fails = 0;
  bit done  = 1'b0;

  localparam logic [1:0] OP_BW = 2'd0;  // byte write
  localparam logic [1:0] OP_BR = 2'd1;  // byte read, val = expected
  localparam logic [1:0] OP_TW = 2'd2;  // bit write, val[0] = bit
  localparam logic [1:0] OP_TR = 2'd3;  // bit read, val = expected
  localparam int NV = 51;

  // {op, address, value, requirement number}
  localparam logic [21:0] VECS [NV] = '{
    {OP_BW, 8'hE0, 8'h5A, 4'd2},
    {OP_BR, 8'hE0, 8'h5A, 4'd2},   // R2
    {OP_BR, 8'hD0, 8'h00, 4'd9},   // R9 even ones -> parity 0
    {OP_BW, 8'hF0, 8'hC3, 4'd2},
    {OP_BR, 8'hF0, 8'hC3, 4'd2},   // R2
    {OP_BW, 8'h81, 8'h3C, 4'd2},
    {OP_BR, 8'h81, 8'h3C, 4'd2},   // R2
    {OP_BW, 8'h99, 8'hA5, 4'd2},
    {OP_BR, 8'h99, 8'hA5, 4'd2},   // R2
    {OP_BR, 8'h98, 8'h00, 4'd2},   // R2 neighbour untouched
    {OP_BW, 8'h83, 8'h12, 4'd2},
    {OP_BR, 8'h83, 8'h12, 4'd2},   // R2
    {OP_BR, 8'h82, 8'h00, 4'd2},   // R2
    {OP_BW, 8'hE0, 8'h01, 4'd9},
    {OP_BR, 8'hD0, 8'h01, 4'd9},   // R9 odd ones -> parity 1
    {OP_BW, 8'hD0, 8'h00, 4'd9},
    {OP_BR, 8'hD0, 8'h01, 4'd9},   // R9 write of 0 to parity ignored
    {OP_BW, 8'hD0, 8'h3E, 4'd8},
    {OP_BR, 8'hD0, 8'h3F, 4'd8},   // R8
    {OP_BW, 8'h7F, 8'h55, 4'd3},
    {OP_BR, 8'h7F, 8'h00, 4'd3},   // R3
    {OP_BW, 8'hC0, 8'h77, 4'd4},
    {OP_BR, 8'hC0, 8'h00, 4'd4},   // R4
    {OP_TW, 8'h93, 8'h00, 4'd6},
    {OP_BR, 8'h90, 8'hF7, 4'd6},   // R6
    {OP_TR, 8'h93, 8'h00, 4'd5},   // R5
    {OP_TR, 8'h92, 8'h01, 4'd5},   // R5
    {OP_TW, 8'hF5, 8'h01, 4'd6},
    {OP_BR, 8'hF0, 8'hE3, 4'd6},   // R6
    {OP_TW, 8'hD0, 8'h00, 4'd9},
    {OP_TR, 8'hD0, 8'h01, 4'd9},   // R9 bit write to parity ignored
    {OP_TW, 8'hD7, 8'h01, 4'd8},
    {OP_BR, 8'hD0, 8'hBF, 4'd8},   // R8 carry is bit 7
    {OP_TR, 8'hD2, 8'h01, 4'd8},   // R8 overflow is bit 2
    {OP_TW, 8'hC3, 8'h01, 4'd7},
    {OP_TR, 8'hC3, 8'h00, 4'd7},   // R7
    {OP_BR, 8'hC0, 8'h00, 4'd7},   // R7
    {OP_TR, 8'h8A, 8'h00, 4'd5},   // R5
    {OP_TW, 8'h8A, 8'h01, 4'd5},
    {OP_BR, 8'h88, 8'h04, 4'd5},   // R5 bit 8Ah is bit 2 of 88h
    {OP_BR, 8'h8A, 8'h00, 4'd5},   // R5 byte-only 8Ah untouched
    {OP_TW, 8'h80, 8'h00, 4'd6},
    {OP_BR, 8'h80, 8'hFE, 4'd6},   // R6
    {OP_TW, 8'hE7, 8'h01, 4'd9},
    {OP_BR, 8'hD0, 8'hBE, 4'd9},   // R9 acc 81h -> parity 0
    {OP_BW, 8'h87, 8'h0F, 4'd2},
    {OP_BR, 8'h87, 8'h0F, 4'd2},   // R2
    {OP_TW, 8'hF8, 8'h01, 4'd7},
    {OP_TR, 8'hF8, 8'h00, 4'd7},   // R7
    {OP_TW, 8'h4A, 8'h01, 4'd3},
    {OP_TR, 8'h4A, 8'h00, 4'd3}    // R3
  };

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic idle();
    byte_rd = 0; byte_wr = 0; byte_addr = 8'h00; byte_wdata = 8'h00;
    bit_rd = 0; bit_wr = 0; bit_addr = 8'h00; bit_wval = 0;
    flag_we = 0; flag_cy = 0; flag_ac = 0; flag_ov = 0;
  endtask

  task automatic bread(input logic [7:0] a, input string req, input logic [7:0] exp);
    @(negedge clk); idle();
    byte_rd = 1; byte_addr = a;
    #1 chk(req, byte_rdata, exp);
  endtask

  task automatic bwrite(input logic [7:0] a, input logic [7:0] v);
    @(negedge clk); idle();
    byte_wr = 1; byte_addr = a; byte_wdata = v;
  endtask

  logic [1:0] op;
  logic [7:0] va, vv;
  logic [3:0] vr;

  initial begin
    idle();
    rst_n = 0;
    repeat (4) @(posedge clk);
    @(negedge clk); rst_n = 1;
    repeat (3) @(negedge clk);

    // R1 reset state
    bread(8'h81, "R1", 8'h07);
    bread(8'h80, "R1", 8'hFF);
    bread(8'h90, "R1", 8'hFF);
    bread(8'hA0, "R1", 8'hFF);
    bread(8'hB0, "R1", 8'hFF);
    bread(8'hE0, "R1", 8'h00);
    bread(8'hD0, "R1", 8'h00);
    bread(8'h88, "R1", 8'h00);
    chk("R1", bank_base, 8'h00);
    @(negedge clk); idle();
    #1 chk("R1", {7'b0, illegal_pulse}, 8'h00);

    // vector walk
    for (int k = 0; k < NV; k++) begin
      @(negedge clk); idle();
      {op, va, vv, vr} = VECS[k];
      case (op)
        OP_BW: begin byte_wr = 1; byte_addr = va; byte_wdata = vv; end
        OP_BR: begin byte_rd = 1; byte_addr = va;
                     #1 chk($sformatf("R%0d", vr), byte_rdata, vv); end
        OP_TW: begin bit_wr = 1; bit_addr = va; bit_wval = vv[0]; end
        default: begin bit_rd = 1; bit_addr = va;
                     #1 chk($sformatf("R%0d", vr), {7'b0, bit_rdata}, vv); end
      endcase
    end

    // R10 bank base for every bank select value
    for (int k = 0; k < 4; k++) begin
      bwrite(8'hD0, 8'(k << 3));
      @(negedge clk); idle();
      #1 chk("R10", bank_base, 8'(k * 8));
    end

    // R4 illegal pulse after byte and bit access to reserved addresses
    bread(8'hC8, "R4", 8'h00);
    @(negedge clk); idle();
    #1 chk("R4", {7'b0, illegal_pulse}, 8'h01);
    @(negedge clk); idle();
    #1 chk("R4", {7'b0, illegal_pulse}, 8'h00);
    @(negedge clk); idle(); bit_rd = 1; bit_addr = 8'hDB;
    @(negedge clk); idle();
    #1 chk("R4", {7'b0, illegal_pulse}, 8'h01);
    // R3 low half: no pulse
    bwrite(8'h10, 8'hAA);
    @(negedge clk); idle();
    #1 chk("R3", {7'b0, illegal_pulse}, 8'h00);
    bread(8'h81, "R4", 8'h3C);
    @(negedge clk); idle();
    #1 chk("R4", {7'b0, illegal_pulse}, 8'h00);

    // R11 flag updates and software priority
    bwrite(8'hE0, 8'h00);
    bwrite(8'hD0, 8'h00);
    @(negedge clk); idle(); flag_we = 1; flag_cy = 1; flag_ac = 0; flag_ov = 1;
    @(negedge clk); idle();
    #1 chk("R11", status_value, 8'h84);
    byte_wr = 1; byte_addr = 8'hD0; byte_wdata = 8'h20;
    flag_we = 1; flag_cy = 0; flag_ac = 1; flag_ov = 0;
    @(negedge clk); idle();
    #1 chk("R11", status_value, 8'h20);
    bit_wr = 1; bit_addr = 8'hD1; bit_wval = 1;
    flag_we = 1; flag_cy = 1; flag_ac = 1; flag_ov = 1;
    @(negedge clk); idle();
    #1 chk("R11", status_value, 8'h22);
    flag_we = 1; flag_cy = 0; flag_ac = 1; flag_ov = 0;
    @(negedge clk); idle();
    #1 chk("R11", status_value, 8'h62);

    // R12 simultaneous byte and bit writes
    @(negedge clk); idle();
    byte_wr = 1; byte_addr = 8'hF0; byte_wdata = 8'h00;
    bit_wr = 1; bit_addr = 8'hF7; bit_wval = 1;
    bread(8'hF0, "R12", 8'h00);
    @(negedge clk); idle();
    byte_wr = 1; byte_addr = 8'h81; byte_wdata = 8'hAA;
    bit_wr = 1; bit_addr = 8'hF1; bit_wval = 1;
    bread(8'h81, "R12", 8'hAA);
    bread(8'hF0, "R12", 8'h02);

    // R9 parity follows accumulator one cycle later
    bwrite(8'hE0, 8'h07);
    @(negedge clk); idle();
    #1 chk("R9", {7'b0, status_value[0]}, 8'h01);
    chk("R9", acc_value, 8'h07);

    @(negedge clk); idle();
    done = 1'b1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

endmodule